// File: doc/BRIEF.md
# Multibank DRAM Command Sequencer

This block sits between a simple request port and a four-bank double-data-rate DRAM command bus. Each accepted request names a bank, a row, a starting column, a direction and an optional auto-precharge flag. The sequencer keeps a record of the open row in every bank. From that record it emits the shortest legal command series for the request. A row hit needs only the access. An idle bank needs an activate and then the access. A bank holding a different row needs a precharge, then an activate, then the access.

Each bank has its own timer. The timer enforces a parameterised activate-to-access gap and a parameterised close-to-activate gap, both counted in clock cycles. An access with auto precharge keeps the bank marked open for the burst duration, which is half the programmed burst length in clock cycles. The bank then closes by itself, and other banks can be activated during that time. The burst length can be programmed to 2, 4 or 8. Any other value written leaves the setting unchanged. Every command, bank select and address is registered and changes only after a rising clock edge.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0, cmd_op is 0, bank_open is all zero and burst_len equals BL_RESET (default 4).
- R2: A request to a bank with no open row produces an activate (cmd_op 1) to that bank, followed by the access. No access is ever issued to a bank without an open row.
- R3: An activate drives the request's bank on cmd_bank and its row on cmd_addr. A read (cmd_op 2) or write (cmd_op 3) drives the bank, the column zero-extended on cmd_addr, and the request's auto-precharge flag on cmd_ap.
- R4: A cfg_we pulse with cfg_bl of 2, 4 or 8 sets burst_len from the next cycle. Any other cfg_bl value leaves burst_len unchanged.
- R5: A request to a bank with a different open row produces a precharge (cmd_op 4), then an activate, then the access.
- R6: A request whose row is already open in its bank produces only the access, with no activate or precharge.
- R7: An access comes at least T_RCD cycles after the activate of its bank. An activate comes at least T_RP cycles after that bank closed.
- R8: After an access with auto precharge in cycle a, bank_open for that bank stays 1 through cycle a+burst_len/2-1 and is 0 from cycle a+burst_len/2. That bank's next activate comes no earlier than cycle a+burst_len/2+T_RP.
- R9: req_ready is 1 exactly when no request is held. It is 0 from the cycle after acceptance until the cycle in which the access command appears.
- R10: An activate to one bank can be issued while another bank is still open in an auto-precharge burst.
- R11: At most one command is issued per cycle. When cmd_valid is 0, cmd_op is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands change after its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Burst length write strobe |
| cfg_bl | input | 4 | Requested burst length |
| burst_len | output | 4 | Burst length in force |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_ap | input | 1 | Close the row after this burst |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_op | output | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_bank | output | BANK_W | Bank select for the command |
| cmd_addr | output | ADDR_W | Row for activate, column for access |
| cmd_ap | output | 1 | Auto-precharge flag on an access |
| bank_open | output | NUM_BANKS | One bit per bank, set while a row is open |

## Verification
The bench targets the row-state transitions: hit, miss on an idle bank, conflict on an open bank, and an access to a bank whose auto-precharge burst has not yet ended. A sequencer that reads stale row state would skip the activate or issue an access to the wrong row. The bench checks the gap timers at their minimum distances, so a timer loaded one short would let an access or activate appear a cycle early. It also checks the exact cycle in which bank_open drops after an auto-precharge burst at several burst lengths. An off-by-one there, or a burst length taken from the wrong register, moves that edge. Illegal burst-length writes are mixed with legal ones to catch a configuration register that accepts any value.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_OPEN  = 3'd1,
      OP_READ  = 3'd2,
      OP_WRITE = 3'd3,
      OP_CLOSE = 3'd4
   } dcs_op_e;

   function automatic logic bl_legal(input logic [3:0] v);
      return (v == 4'd2) || (v == 4'd4) || (v == 4'd8);
   endfunction
endpackage

// File: rtl/dcs_burst_cfg.sv
module dcs_burst_cfg
   import dcs_pkg::*;
#(
   parameter int BL_RESET = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [3:0] wr_val,
   output logic [3:0] bl_q
);
   if (!(BL_RESET == 2 || BL_RESET == 4 || BL_RESET == 8)) begin : g_bad_reset
      $error("dcs_burst_cfg: BL_RESET must be 2, 4 or 8");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bl_q <= 4'(BL_RESET);
      end else if (wr_en && bl_legal(wr_val)) begin
         bl_q <= wr_val;
      end
   end

   AST_BL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      bl_legal(bl_q)); // R4
   AST_BL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !bl_legal(wr_val)) |=> $stable(bl_q)); // R4
endmodule

// File: rtl/dcs_bank_tracker.sv
module dcs_bank_tracker #(
   parameter int ROW_W = 13,
   parameter int T_RCD = 3,
   parameter int T_RP  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_fire,
   input  logic             pre_fire,
   input  logic             acc_fire,
   input  logic             acc_ap,
   input  logic [ROW_W-1:0] act_row,
   input  logic [3:0]       burst_len,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             timer_ok,
   output logic             closing
);
   localparam int TMAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
   localparam int CNT_W = $clog2(TMAX + 1);

   logic             open_q;
   logic [ROW_W-1:0] row_q;
   logic [CNT_W-1:0] tmr_q;
   logic [3:0]       burst_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         row_q   <= '0;
         tmr_q   <= '0;
         burst_q <= '0;
      end else begin
         if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
         if (burst_q != '0) begin
            burst_q <= burst_q - 1'b1;
            if (burst_q == 4'd1) begin
               open_q <= 1'b0;
               tmr_q  <= CNT_W'(T_RP - 1);
            end
         end
         if (act_fire) begin
            open_q <= 1'b1;
            row_q  <= act_row;
            tmr_q  <= CNT_W'(T_RCD - 1);
         end
         if (pre_fire) begin
            open_q <= 1'b0;
            tmr_q  <= CNT_W'(T_RP - 1);
         end
         if (acc_fire && acc_ap) burst_q <= burst_len >> 1;
      end
   end

   assign open_o   = open_q;
   assign row_o    = row_q;
   assign timer_ok = (tmr_q == '0);
   assign closing  = (burst_q != '0);

   AST_ACC_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fire |-> (open_q && burst_q == '0)); // R2
   AST_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      act_fire |-> (!open_q && tmr_q == '0)); // R7
   AST_AP_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(open_q) && !$past(pre_fire)) |-> ($past(burst_q) == 4'd1)); // R8
   AST_ONE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({act_fire, pre_fire, acc_fire})); // R11
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
   import dcs_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 13,
   parameter int COL_W     = 11,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int BL_RESET  = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [3:0]           cfg_bl,
   output logic [3:0]           burst_len,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic                 req_ap,
   input  logic [BANK_W-1:0]    req_bank,
   input  logic [ROW_W-1:0]     req_row,
   input  logic [COL_W-1:0]     req_col,
   output logic                 cmd_valid,
   output logic [2:0]           cmd_op,
   output logic [BANK_W-1:0]    cmd_bank,
   output logic [ADDR_W-1:0]    cmd_addr,
   output logic                 cmd_ap,
   output logic [NUM_BANKS-1:0] bank_open
);
   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("dram_cmd_seq: NUM_BANKS must be a power of two, at least 2");
   end
   if (T_RCD < 1 || T_RP < 1) begin : g_bad_gaps
      $error("dram_cmd_seq: T_RCD and T_RP must be at least 1");
   end

   // held request
   logic              pend_q;
   logic              wr_q, ap_q;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic [ADDR_W-1:0] row_ext, col_ext;

   logic [3:0]           bl;
   logic [NUM_BANKS-1:0] open_v, ok_v, closing_v;
   logic [NUM_BANKS-1:0] act_v, pre_v, acc_v;
   logic [ROW_W-1:0]     row_v [NUM_BANKS];

   logic    do_act, do_pre, do_acc;
   dcs_op_e op_n;

   dcs_burst_cfg #(.BL_RESET(BL_RESET)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_val(cfg_bl), .bl_q(bl)
   );
   assign burst_len = bl;

   if (ROW_W == ADDR_W) begin : g_row_full
      assign row_ext = row_q;
   end else begin : g_row_pad
      assign row_ext = {{(ADDR_W-ROW_W){1'b0}}, row_q};
   end
   if (COL_W == ADDR_W) begin : g_col_full
      assign col_ext = col_q;
   end else begin : g_col_pad
      assign col_ext = {{(ADDR_W-COL_W){1'b0}}, col_q};
   end

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      assign act_v[g] = do_act && (bank_q == BANK_W'(g));
      assign pre_v[g] = do_pre && (bank_q == BANK_W'(g));
      assign acc_v[g] = do_acc && (bank_q == BANK_W'(g));
      dcs_bank_tracker #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP)) u_trk (
         .clk(clk), .rst_n(rst_n),
         .act_fire(act_v[g]), .pre_fire(pre_v[g]), .acc_fire(acc_v[g]),
         .acc_ap(ap_q), .act_row(row_q), .burst_len(bl),
         .open_o(open_v[g]), .row_o(row_v[g]),
         .timer_ok(ok_v[g]), .closing(closing_v[g])
      );
   end

   // pick the next command for the held request
   always_comb begin
      do_act = 1'b0;
      do_pre = 1'b0;
      do_acc = 1'b0;
      if (pend_q && !closing_v[bank_q] && ok_v[bank_q]) begin
         if (!open_v[bank_q])              do_act = 1'b1;
         else if (row_v[bank_q] == row_q)  do_acc = 1'b1;
         else                              do_pre = 1'b1;
      end
      if (do_act)      op_n = OP_OPEN;
      else if (do_pre) op_n = OP_CLOSE;
      else if (do_acc) op_n = wr_q ? OP_WRITE : OP_READ;
      else             op_n = OP_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         wr_q      <= 1'b0;
         ap_q      <= 1'b0;
         bank_q    <= '0;
         row_q     <= '0;
         col_q     <= '0;
         cmd_valid <= 1'b0;
         cmd_op    <= 3'd0;
         cmd_bank  <= '0;
         cmd_addr  <= '0;
         cmd_ap    <= 1'b0;
      end else begin
         cmd_valid <= do_act | do_pre | do_acc;
         cmd_op    <= 3'(op_n);
         cmd_bank  <= bank_q;
         cmd_addr  <= do_act ? row_ext : (do_acc ? col_ext : '0);
         cmd_ap    <= do_acc && ap_q;
         if (!pend_q && req_valid) begin
            pend_q <= 1'b1;
            wr_q   <= req_write;
            ap_q   <= req_ap;
            bank_q <= req_bank;
            row_q  <= req_row;
            col_q  <= req_col;
         end else if (do_acc) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign req_ready = !pend_q;
   assign bank_open = open_v;

   AST_ONE_BANK_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_v | pre_v | acc_v)); // R11
   AST_NOP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (cmd_op == 3'd0)); // R11
   AST_READY_LOW_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == 3'd1 || cmd_op == 3'd4)) |-> !req_ready); // R9
   AST_ACCESS_FREES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3)) |-> req_ready); // R9
endmodule

// File: tb/tb_dram_cmd_seq.sv
`timescale 1ns/1ps
module tb_dram_cmd_seq;
   localparam int RW = 13, CW = 11, AW = 13, TRCD = 3, TRP = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n, cfg_we, req_valid, req_write, req_ap;
   logic [3:0]    cfg_bl, burst_len;
   logic          req_ready, cmd_valid, cmd_ap;
   logic [1:0]    req_bank, cmd_bank;
   logic [RW-1:0] req_row;
   logic [CW-1:0] req_col;
   logic [2:0]    cmd_op;
   logic [AW-1:0] cmd_addr;
   logic [3:0]    bank_open;

   dram_cmd_seq #(.NUM_BANKS(4), .ROW_W(RW), .COL_W(CW), .T_RCD(TRCD),
                  .T_RP(TRP), .BL_RESET(4)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bl(cfg_bl),
      .burst_len(burst_len), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_ap(req_ap), .req_bank(req_bank),
      .req_row(req_row), .req_col(req_col), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
      .cmd_ap(cmd_ap), .bank_open(bank_open)
   );

   int     checks = 0, errors = 0;
   longint cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // reference state per bank
   bit          mopen [4];
   logic [RW-1:0] mrow [4];
   longint      act_ok [4], acc_ok [4], idle_at [4];
   int          mbl = 4;
   bit          act_during_ap = 0;

   function automatic bit legal_bl(input int v);
      return v == 2 || v == 4 || v == 8;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "WATCHDOG", "run did not end", cyc, 150000);
      finish_run();
   end

   // called at the falling edge after each rising edge
   task automatic observe();
      int b;
      b = int'(cmd_bank);
      if (!cmd_valid) begin
         chk(cmd_op == 3'd0, "R11", "op while idle", cmd_op, 0);
      end else begin
         case (cmd_op)
            3'd1: begin
               chk(!mopen[b], "R2", "activate on open bank", mopen[b], 0);
               chk(cyc >= act_ok[b], "R7", "close-to-activate gap", cyc, act_ok[b]);
               if (b != 0 && bank_open[0] && cyc < idle_at[0]) act_during_ap = 1;
               mopen[b] = 1; mrow[b] = cmd_addr[RW-1:0]; acc_ok[b] = cyc + TRCD;
            end
            3'd4: begin
               chk(mopen[b], "R5", "precharge on idle bank", mopen[b], 1);
               mopen[b] = 0; act_ok[b] = cyc + TRP;
            end
            3'd2, 3'd3: begin
               chk(mopen[b], "R2", "access to idle bank", mopen[b], 1);
               chk(cyc >= acc_ok[b], "R7", "activate-to-access gap", cyc, acc_ok[b]);
               if (cmd_ap) begin
                  mopen[b] = 0; idle_at[b] = cyc + mbl / 2; act_ok[b] = idle_at[b] + TRP;
               end
            end
            default: chk(0, "R11", "unknown op", cmd_op, 0);
         endcase
      end
      for (int k = 0; k < 4; k++)
         chk(bank_open[k] == (mopen[k] || cyc < idle_at[k]), "R8", "bank_open bit",
             bank_open[k], mopen[k] || cyc < idle_at[k]);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      observe();
   endtask

   task automatic set_bl(input int v);
      int expv;
      expv = legal_bl(v) ? v : mbl;
      cfg_we = 1'b1; cfg_bl = 4'(v);
      step();
      cfg_we = 1'b0;
      mbl = expv;
      chk(int'(burst_len) == expv, "R4", "burst_len after write", burst_len, expv);
   endtask

   task automatic do_req(input bit w, input bit ap, input int b,
                         input logic [RW-1:0] row, input logic [CW-1:0] col);
      int exp_ops [3];
      int n, idx, guard;
      bit done;
      string tag;
      if (mopen[b] && mrow[b] == row) begin
         n = 1; exp_ops[0] = w ? 3 : 2; tag = "R6";
      end else if (mopen[b]) begin
         n = 3; exp_ops[0] = 4; exp_ops[1] = 1; exp_ops[2] = w ? 3 : 2; tag = "R5";
      end else begin
         n = 2; exp_ops[0] = 1; exp_ops[1] = w ? 3 : 2; tag = "R2";
      end
      chk(req_ready, "R9", "ready before request", req_ready, 1);
      req_valid = 1'b1; req_write = w; req_ap = ap;
      req_bank = 2'(b); req_row = row; req_col = col;
      step();
      req_valid = 1'b0;
      chk(!req_ready, "R9", "ready after accept", req_ready, 0);
      idx = 0; done = 0; guard = 0;
      while (!done && guard < 64) begin
         step();
         guard++;
         if (cmd_valid) begin
            chk(idx < n && int'(cmd_op) == exp_ops[idx], tag, "command order",
                cmd_op, (idx < n) ? exp_ops[idx] : -1);
            chk(int'(cmd_bank) == b, "R3", "bank select", cmd_bank, b);
            if (cmd_op == 3'd1)
               chk(cmd_addr == AW'(row), "R3", "activate row", cmd_addr, row);
            if (cmd_op == 3'd2 || cmd_op == 3'd3) begin
               chk(cmd_addr == AW'(col), "R3", "access column", cmd_addr, col);
               chk(cmd_ap == ap, "R3", "auto-precharge flag", cmd_ap, ap);
               chk(req_ready, "R9", "ready with access", req_ready, 1);
               done = 1;
            end
            if (idx < n) idx++;
         end else begin
            chk(!req_ready, "R9", "ready during setup", req_ready, 0);
         end
      end
      chk(done && idx == n, tag, "sequence completed", idx, n);
   endtask

   initial begin
      int r;
      for (int k = 0; k < 4; k++) begin
         mopen[k] = 0; mrow[k] = '0; act_ok[k] = 0; acc_ok[k] = 0; idle_at[k] = 0;
      end
      process::self().srandom(32'd1234);
      rst_n = 1'b0; cfg_we = 1'b0; cfg_bl = 4'd0; req_valid = 1'b0;
      req_write = 1'b0; req_ap = 1'b0; req_bank = '0; req_row = '0; req_col = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
      chk(cmd_valid == 1'b0, "R1", "cmd_valid", cmd_valid, 0);
      chk(cmd_op == 3'd0, "R1", "cmd_op", cmd_op, 0);
      chk(bank_open == 4'd0, "R1", "bank_open", bank_open, 0);
      chk(burst_len == 4'd4, "R1", "burst_len", burst_len, 4);
      step();
      // R4 legal and illegal burst settings
      set_bl(3); set_bl(8); set_bl(0); set_bl(15); set_bl(2); set_bl(6); set_bl(8);
      // R2 idle bank, R6 hit, R5 conflict
      do_req(0, 0, 0, 13'd5, 11'd17);
      do_req(1, 0, 0, 13'd5, 11'd2047);
      do_req(0, 0, 0, 13'd9, 11'd3);
      // R8 auto precharge then R10 activate on another bank during that burst
      do_req(1, 1, 0, 13'd9, 11'd40);
      do_req(0, 0, 1, 13'd1, 11'd7);
      chk(act_during_ap, "R10", "activate overlapped open burst", act_during_ap, 1);
      do_req(0, 0, 0, 13'd9, 11'd8);
      set_bl(2);
      do_req(1, 1, 2, 13'd8191, 11'd0);
      do_req(1, 1, 2, 13'd8191, 11'd1);
      set_bl(4);
      // constrained random traffic over a few rows to mix hits and conflicts
      for (int i = 0; i < 400; i++) begin
         r = $urandom_range(0, 9);
         if (r == 0) set_bl(int'($urandom_range(0, 15)));
         repeat ($urandom_range(0, 3)) step();
         do_req(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                int'($urandom_range(0, 3)), 13'($urandom_range(0, 3)),
                11'($urandom_range(0, 2047)));
      end
      repeat (20) step();
      finish_run();
   end
endmodule